// File: doc/BRIEF.md
# Clock Generator Power-Up Strap Latch and Frequency Selector

This block runs the power-up sequence of a clock generator whose five configuration pins are shared with clock outputs. While the power-good indication is low, those pins are inputs. On the rising edge of power-good the block samples them once, into a frequency code, an operating-mode bit and a CPU output-supply bit. It then turns the shared pins and the other clock outputs into outputs that drive low. A stabilisation timer then runs, counted in reference-clock cycles, and when it ends the clocks are released to toggle.

Alongside the sequence, a selector picks the active 3-bit frequency index. It uses either the code latched from the pins or a code written by software, depending on a software select bit. An eight-entry lookup turns the chosen index into nominal CPU, PCI and AGP output rates, in units of 10 kHz, for the dividers that follow. A parameter picks one of two tables. The PLL and the dividers themselves lie outside this block.

Top module: `clkgen_strap_boot`

## Requirements
- R1: During reset and in the sensing phase before the first power-good rising edge, `strap_oe`, `clk_oe`, `hold_low` and `clk_release` are all 0, so every pin is tristated.
- R2: Before capture, the latched values read as all ones, as the pad pull-ups make a floating pin read 1. So `mode_out`=1, `cpu_lv`=1 and the hardware code is 7. Changes on `pin_in` during the sensing phase do not alter them.
- R3: On the first clock edge at which `pwr_good` is seen high after being low, `pin_in` is latched with this bit mapping: bit 0 is the supply select (1 = CPU outputs on 2.5 V, 0 = 3.3 V), bits 1/2/3 are code bits 0/1/2, and bit 4 is the mode bit. The new values appear at the outputs right after that edge.
- R4: The capture happens once. Later changes on `pin_in` and later falls and rises of `pwr_good` never change `mode_out`, `cpu_lv` or the latched code, until the next reset.
- R5: From the clock edge that captures the straps, `strap_oe` is all ones, `clk_oe`=1 and `hold_low`=1. The shared pins and the other clock outputs are driven low.
- R6: The drive-low phase lasts exactly `PWRUP_CYCLES` reference-clock cycles. The default is 42954, about 3 ms at 14.318 MHz. After that, `clk_release` becomes 1 and `hold_low` becomes 0.
- R7: Once `clk_release` is 1 it stays 1 until reset, whatever `pwr_good` does.
- R8: With `sw_sel`=0, `freq_idx` equals the latched hardware code. With `sw_sel`=1 it equals `sw_code`. The switch takes effect without a clock edge.
- R9: With `VARIANT`=0 the rates for index 0..7 are as follows. CPU: 6000, 6680, 6850, 7500, 7500, 8330, 9000, 10000. PCI: 3000, 3340, 3425, 3750, 3200, 3330, 3000, 3330. AGP: 6000, 6680, 6850, 7500, 6400, 6660, 6000, 6660. `VARIANT`=1 selects a second table that reaches 13330 on the CPU output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset (true power-on) |
| pwr_good | input | 1 | Supply-threshold indication; its rising edge triggers capture |
| pin_in | input | 5 | Levels seen on the shared pins (after pad pull-up) |
| sw_sel | input | 1 | 1 = use software code, 0 = use latched code |
| sw_code | input | 3 | Software frequency code |
| strap_oe | output | 5 | Output enable per shared pin |
| clk_oe | output | 1 | Output enable for all other clock outputs |
| hold_low | output | 1 | Enabled outputs must drive low |
| clk_release | output | 1 | Clocks may toggle |
| mode_out | output | 1 | Latched mode bit |
| cpu_lv | output | 1 | Latched CPU supply select (1 = 2.5 V) |
| freq_idx | output | 3 | Selected frequency index |
| cpu_rate | output | 16 | CPU/SDRAM rate, 10 kHz units |
| pci_rate | output | 16 | PCI rate, 10 kHz units |
| agp_rate | output | 16 | AGP rate, 10 kHz units |

## Verification
A phase register that enters or leaves a state at the wrong time shows up first on `strap_oe`, `hold_low` or `clk_release`, in the cycle after the edge where it went wrong. An off-by-one timer shifts the rise of `clk_release` by a single cycle, so the bench samples the cycles just before and just after the expected release. A capture register that reloads, or that maps a pin to the wrong bit, shows at once on `mode_out`, `cpu_lv` or `freq_idx`, and through the lookup on the three rate outputs. The bench therefore drives two complementary pin patterns and then disturbs the pins and power-good after capture.

// File: rtl/clkgen_strap_pkg.sv
package clkgen_strap_pkg;

    localparam int STRAP_N   = 5;
    localparam int LV_POS    = 0;
    localparam int FS_LO     = 1;
    localparam int MODE_POS  = 4;
    localparam int CODE_W    = 3;
    localparam int RATE_W    = 16;

    typedef struct packed {
        logic              mode;
        logic [CODE_W-1:0] fs;
        logic              cpu_lv;
    } strap_t;

    localparam strap_t STRAP_DEFAULT = '{mode: 1'b1, fs: '1, cpu_lv: 1'b1};

    typedef enum logic [1:0] {
        PH_SENSE = 2'd0,
        PH_HOLD  = 2'd1,
        PH_RUN   = 2'd2
    } boot_phase_e;

    typedef struct packed {
        logic [RATE_W-1:0] cpu;
        logic [RATE_W-1:0] pci;
        logic [RATE_W-1:0] agp;
    } rate_t;

    function automatic strap_t unpack_pins(input logic [STRAP_N-1:0] p);
        strap_t s;
        s.cpu_lv = p[LV_POS];
        s.fs     = p[FS_LO +: CODE_W];
        s.mode   = p[MODE_POS];
        return s;
    endfunction

    function automatic rate_t mk_rate(input int c, input int p, input int a);
        rate_t r;
        r.cpu = RATE_W'(c);
        r.pci = RATE_W'(p);
        r.agp = RATE_W'(a);
        return r;
    endfunction

    function automatic rate_t rate_std(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    return mk_rate(6000,  3000, 6000);
            3'd1:    return mk_rate(6680,  3340, 6680);
            3'd2:    return mk_rate(6850,  3425, 6850);
            3'd3:    return mk_rate(7500,  3750, 7500);
            3'd4:    return mk_rate(7500,  3200, 6400);
            3'd5:    return mk_rate(8330,  3330, 6660);
            3'd6:    return mk_rate(9000,  3000, 6000);
            default: return mk_rate(10000, 3330, 6660);
        endcase
    endfunction

    function automatic rate_t rate_fast(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    return mk_rate(11200, 3730, 7470);
            3'd1:    return mk_rate(6680,  3340, 6680);
            3'd2:    return mk_rate(12400, 3100, 6200);
            3'd3:    return mk_rate(7500,  3750, 7500);
            3'd4:    return mk_rate(13330, 3330, 6660);
            3'd5:    return mk_rate(8330,  3330, 6660);
            3'd6:    return mk_rate(9525,  3175, 6350);
            default: return mk_rate(10020, 3340, 6680);
        endcase
    endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import clkgen_strap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               capture_en,
    input  logic [STRAP_N-1:0] pins,
    output strap_t             latched
);

    always_ff @(posedge clk) begin
        if (rst) begin
            latched <= STRAP_DEFAULT;
        end else if (capture_en) begin
            latched <= unpack_pins(pins);
        end
    end

endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
    import clkgen_strap_pkg::*;
#(
    parameter int PWRUP_CYCLES = 42954
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_good,
    output logic        capture_en,
    output boot_phase_e phase
);

    localparam int CNT_W = (PWRUP_CYCLES < 2) ? 1 : $clog2(PWRUP_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PWRUP_CYCLES - 1);

    logic             pg_q;
    logic [CNT_W-1:0] cnt;

    assign capture_en = (phase == PH_SENSE) && pwr_good && !pg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pg_q  <= 1'b0;
            cnt   <= '0;
            phase <= PH_SENSE;
        end else begin
            pg_q <= pwr_good;
            unique case (phase)
                PH_SENSE: begin
                    cnt <= '0;
                    if (capture_en) phase <= PH_HOLD;
                end
                PH_HOLD: begin
                    if (cnt == CNT_LAST) begin
                        phase <= PH_RUN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_RUN;
            endcase
        end
    end

endmodule

// File: rtl/freq_select.sv
module freq_select
    import clkgen_strap_pkg::*;
#(
    parameter int VARIANT = 0
) (
    input  logic [CODE_W-1:0] hw_code,
    input  logic              sw_sel,
    input  logic [CODE_W-1:0] sw_code,
    output logic [CODE_W-1:0] freq_idx,
    output rate_t             rates
);

    assign freq_idx = sw_sel ? sw_code : hw_code;

    generate
        if (VARIANT == 0) begin : g_std
            assign rates = rate_std(freq_idx);
        end else begin : g_fast
            assign rates = rate_fast(freq_idx);
        end
    endgenerate

endmodule

// File: rtl/clkgen_strap_boot.sv
module clkgen_strap_boot
    import clkgen_strap_pkg::*;
#(
    parameter int PWRUP_CYCLES = 42954,
    parameter int VARIANT      = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_good,
    input  logic [STRAP_N-1:0] pin_in,
    input  logic               sw_sel,
    input  logic [CODE_W-1:0]  sw_code,
    output logic [STRAP_N-1:0] strap_oe,
    output logic               clk_oe,
    output logic               hold_low,
    output logic               clk_release,
    output logic               mode_out,
    output logic               cpu_lv,
    output logic [CODE_W-1:0]  freq_idx,
    output logic [RATE_W-1:0]  cpu_rate,
    output logic [RATE_W-1:0]  pci_rate,
    output logic [RATE_W-1:0]  agp_rate
);

    boot_phase_e       phase;
    logic              capture_en;
    strap_t            latched;
    rate_t             rates;
    logic [CODE_W-1:0] hw_code;

    boot_sequencer #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pwr_good   (pwr_good),
        .capture_en (capture_en),
        .phase      (phase)
    );

    strap_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .capture_en (capture_en),
        .pins       (pin_in),
        .latched    (latched)
    );

    assign hw_code = latched.fs;

    freq_select #(.VARIANT(VARIANT)) u_sel (
        .hw_code  (hw_code),
        .sw_sel   (sw_sel),
        .sw_code  (sw_code),
        .freq_idx (freq_idx),
        .rates    (rates)
    );

    genvar gi;
    generate
        for (gi = 0; gi < STRAP_N; gi++) begin : g_oe
            assign strap_oe[gi] = (phase != PH_SENSE);
        end
    endgenerate

    assign clk_oe      = (phase != PH_SENSE);
    assign hold_low    = (phase == PH_HOLD);
    assign clk_release = (phase == PH_RUN);
    assign mode_out    = latched.mode;
    assign cpu_lv      = latched.cpu_lv;
    assign cpu_rate    = rates.cpu;
    assign pci_rate    = rates.pci;
    assign agp_rate    = rates.agp;

endmodule

// File: rtl/clkgen_strap_boot_chk.sv
module clkgen_strap_boot_chk #(
    parameter int PWRUP_CYCLES = 42954
) (
    input logic       clk,
    input logic       rst,
    input logic       pwr_good,
    input logic [4:0] strap_oe,
    input logic       clk_oe,
    input logic       hold_low,
    input logic       clk_release,
    input logic       mode_out,
    input logic       cpu_lv,
    input logic [2:0] hw_code
);

    int unsigned hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= 0;
        end else if (hold_low) begin
            hold_cnt <= hold_cnt + 1;
        end
    end

    // R1
    sense_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !clk_oe |-> (!hold_low && !clk_release && strap_oe == 5'b0));

    // R2
    sense_default_chk: assert property (@(posedge clk) disable iff (rst)
        (!clk_oe && !$past(clk_oe)) |-> (mode_out && cpu_lv && hw_code == 3'b111));

    // R3
    capture_after_pg_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_oe) |-> $past(pwr_good));

    // R4
    no_recapture_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clk_oe) |-> ($stable(mode_out) && $stable(cpu_lv) && $stable(hw_code)));

    // R5
    hold_drive_chk: assert property (@(posedge clk) disable iff (rst)
        hold_low |-> (clk_oe && strap_oe == 5'b11111 && !clk_release));

    // R6
    hold_length_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_release) |-> (hold_cnt == PWRUP_CYCLES));

    // R7
    release_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        clk_release |=> clk_release);

endmodule

bind clkgen_strap_boot clkgen_strap_boot_chk #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_good    (pwr_good),
    .strap_oe    (strap_oe),
    .clk_oe      (clk_oe),
    .hold_low    (hold_low),
    .clk_release (clk_release),
    .mode_out    (mode_out),
    .cpu_lv      (cpu_lv),
    .hw_code     (hw_code)
);

// File: tb/clkgen_strap_boot_bench.sv
module clkgen_strap_boot_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PWR        = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_good = 1'b0;
    logic [4:0]  pin_in = 5'b0;
    logic        sw_sel = 1'b0;
    logic [2:0]  sw_code = 3'b0;
    logic [4:0]  strap_oe;
    logic        clk_oe, hold_low, clk_release, mode_out, cpu_lv;
    logic [2:0]  freq_idx;
    logic [15:0] cpu_rate, pci_rate, agp_rate;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkgen_strap_boot #(.PWRUP_CYCLES(PWR), .VARIANT(0)) u_clkgen_strap_boot (
        .clk, .rst, .pwr_good, .pin_in, .sw_sel, .sw_code,
        .strap_oe, .clk_oe, .hold_low, .clk_release, .mode_out, .cpu_lv,
        .freq_idx, .cpu_rate, .pci_rate, .agp_rate
    );

    function automatic int exp_rate(input int code, input int which);
        int c[8] = '{6000, 6680, 6850, 7500, 7500, 8330, 9000, 10000};
        int p[8] = '{3000, 3340, 3425, 3750, 3200, 3330, 3000, 3330};
        int a[8] = '{6000, 6680, 6850, 7500, 6400, 6660, 6000, 6660};
        if (which == 0) return c[code];
        if (which == 1) return p[code];
        return a[code];
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [4:0] pins);
        @(negedge clk);
        rst = 1'b1; pwr_good = 1'b0; pin_in = pins; sw_sel = 1'b0; sw_code = 3'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_defaults();
        do_reset(5'b00000);
        chk("R1", "strap_oe", int'(strap_oe), 0);
        chk("R1", "clk_oe", int'(clk_oe), 0);
        chk("R1", "hold_low", int'(hold_low), 0);
        chk("R1", "clk_release", int'(clk_release), 0);
        chk("R2", "mode_out", int'(mode_out), 1);
        chk("R2", "cpu_lv", int'(cpu_lv), 1);
        chk("R2", "freq_idx", int'(freq_idx), 7);
        pin_in = 5'b01010;
        repeat (3) @(negedge clk);
        pin_in = 5'b10101;
        repeat (3) @(negedge clk);
        chk("R2", "mode after pin wiggle", int'(mode_out), 1);
        chk("R2", "cpu_lv after pin wiggle", int'(cpu_lv), 1);
        chk("R2", "idx after pin wiggle", int'(freq_idx), 7);
        chk("R1", "clk_oe still off", int'(clk_oe), 0);
    endtask

    task automatic t_capture_hold(input logic [4:0] pat, input int e_mode,
                                  input int e_lv, input int e_code);
        do_reset(5'b11111);
        pin_in = pat;
        pwr_good = 1'b1;
        @(negedge clk);
        chk("R5", "strap_oe", int'(strap_oe), 31);
        chk("R5", "clk_oe", int'(clk_oe), 1);
        chk("R5", "hold_low", int'(hold_low), 1);
        chk("R3", "mode_out", int'(mode_out), e_mode);
        chk("R3", "cpu_lv", int'(cpu_lv), e_lv);
        chk("R3", "freq_idx", int'(freq_idx), e_code);
        chk("R3", "cpu_rate", int'(cpu_rate), exp_rate(e_code, 0));
        repeat (PWR - 1) @(negedge clk);
        chk("R6", "release one cycle early", int'(clk_release), 0);
        chk("R6", "hold one cycle early", int'(hold_low), 1);
        @(negedge clk);
        chk("R6", "release at end", int'(clk_release), 1);
        chk("R6", "hold at end", int'(hold_low), 0);
        chk("R6", "clk_oe at end", int'(clk_oe), 1);
    endtask

    task automatic t_no_recapture(input int e_mode, input int e_lv, input int e_code);
        pin_in = ~pin_in;
        pwr_good = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7", "release after pg low", int'(clk_release), 1);
        pwr_good = 1'b1;
        repeat (5) @(negedge clk);
        chk("R4", "mode_out", int'(mode_out), e_mode);
        chk("R4", "cpu_lv", int'(cpu_lv), e_lv);
        chk("R4", "freq_idx", int'(freq_idx), e_code);
        chk("R7", "release after pg rise", int'(clk_release), 1);
    endtask

    task automatic t_select(input int hw);
        sw_sel = 1'b1; sw_code = 3'd3;
        #1;
        chk("R8", "sw code", int'(freq_idx), 3);
        chk("R8", "sw code rate", int'(cpu_rate), 7500);
        sw_sel = 1'b0;
        #1;
        chk("R8", "back to hw code", int'(freq_idx), hw);
    endtask

    task automatic t_lookup();
        sw_sel = 1'b1;
        for (int k = 0; k < 8; k++) begin
            sw_code = 3'(k);
            #1;
            chk("R9", $sformatf("cpu[%0d]", k), int'(cpu_rate), exp_rate(k, 0));
            chk("R9", $sformatf("pci[%0d]", k), int'(pci_rate), exp_rate(k, 1));
            chk("R9", $sformatf("agp[%0d]", k), int'(agp_rate), exp_rate(k, 2));
        end
        sw_sel = 1'b0;
    endtask

    initial begin
        t_reset_defaults();
        // pins: mode=0, FS2=1, FS1=0, FS0=1, lv=0 -> code 5
        t_capture_hold(5'b01010, 0, 0, 5);
        t_no_recapture(0, 0, 5);
        t_select(5);
        // pins: mode=1, FS2=0, FS1=1, FS0=0, lv=1 -> code 2
        t_capture_hold(5'b10101, 1, 1, 2);
        t_no_recapture(1, 1, 2);
        t_select(2);
        t_lookup();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule